// File: doc/BRIEF.md
# Timer Channel with Selectable Counter Clear

This block is one channel of a free-running up-counter timer. It holds a counter and four general registers, named A, B, C and D. Each general register either compares its value with the counter or latches the counter when its capture pin is strobed. A three-bit clear-select field chooses which event returns the counter to zero. The choices are no event, an event on one of the four general registers, or a clear broadcast by another channel of the same synchronous group.

Registers C and D can act as buffers for A and B. A buffering register raises no event of its own. Instead it trades values with its partner: on a capture of the partner it receives the partner's old value, and on a compare match of the partner it reloads the partner. When this channel clears its own counter and its group-sync enable is set, it raises a sync-clear output in that same cycle so that peer channels can clear on the same clock edge. A parameter builds a reduced variant in which the top bit of the clear-select field is held at zero.

Top module: `timer_chan_clr`

## Requirements
- R1: After reset the counter, all four general registers and the control word read 0. The register map is: address 0 control, 1 counter, 2 to 5 registers A to D. The control fields are: bits 2:0 clear-select, bit 3 group-sync enable, bits 7:4 capture mode for A to D (1 selects capture, 0 selects compare), bit 8 C buffers A, bit 9 D buffers B.
- R2: In each cycle where tick is high and no clear or counter write occurs, the counter increments by one and wraps from 0xFFFF to 0.
- R3: Clear-select 001 (or 010) clears the counter on an event of register A (or B). A compare-mode register raises its event on a tick where the counter equals its value, and the counter then reads 0 instead of advancing.
- R4: A capture strobe on a capture-mode register latches the current counter value into that register. If that register is the selected clear source, the counter reads 0 after that cycle.
- R5: Clear-select 101 (or 110) clears the counter on an event of register C (or D). Codes 000 and 100 never clear the counter.
- R6: Clear-select 011 and 111 clear the counter when sync_clr_in is high, but only while the group-sync enable is set. With the enable low, sync_clr_in has no effect.
- R7: sync_clr_out is high in exactly those cycles where the channel clears its own counter from a register event while the group-sync enable is set.
- R8: A register in buffer mode raises no event, so selecting C (or D) as clear source while it buffers never clears the counter.
- R9: With C buffering A, a capture on A moves A's old value into C, and a compare match of A loads A from C. The same holds for D and B.
- R10: With FULL_CLR = 0, bit 2 of clear-select always reads 0 and ignores writes.
- R11: A counter write in the same cycle as a clear or a tick takes priority, and the counter then holds the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable for this cycle |
| cap_in | input | 4 | Capture strobes for registers A to D |
| sync_clr_in | input | 1 | Clear broadcast from a peer channel |
| sync_clr_out | output | 1 | Clear broadcast to peer channels |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for bus_addr |

## Verification
The assertions check four rules on every cycle: a self clear leaves the counter at zero, a counter write overrides everything else, an undisturbed tick adds exactly one, and a capture latches the counter into the register the following cycle. They also check that the sync output is never raised without the enable, and that a buffering C never causes a clear. The bench scenarios are needed for the decoding of all eight clear-select codes against actual match timing, the period each code produces and how many sync pulses it gives, the value swaps in buffer mode, and the masked field of the reduced variant.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [2:0] {
        CLR_OFF   = 3'd0,
        CLR_A     = 3'd1,
        CLR_B     = 3'd2,
        CLR_GRP   = 3'd3,
        CLR_OFF2  = 3'd4,
        CLR_C     = 3'd5,
        CLR_D     = 3'd6,
        CLR_GRP2  = 3'd7
    } clr_sel_e;

    typedef enum logic [2:0] {
        ADR_CTRL = 3'd0,
        ADR_CNT  = 3'd1,
        ADR_GRA  = 3'd2,
        ADR_GRB  = 3'd3,
        ADR_GRC  = 3'd4,
        ADR_GRD  = 3'd5
    } tmr_addr_e;

    typedef struct packed {
        logic       buf_d;
        logic       buf_c;
        logic [3:0] cap_mode;
        logic       grp_en;
        clr_sel_e   sel;
    } tmr_ctrl_t;

    localparam int CTRL_W = $bits(tmr_ctrl_t);
    localparam int NGR    = 4;

    // Self clear from register events for the chosen code
    function automatic logic self_clear(clr_sel_e sel, logic [NGR-1:0] evt);
        case (sel)
            CLR_A:   return evt[0];
            CLR_B:   return evt[1];
            CLR_C:   return evt[2];
            CLR_D:   return evt[3];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic is_group(clr_sel_e sel);
        return (sel == CLR_GRP) || (sel == CLR_GRP2);
    endfunction

endpackage

// File: rtl/tmr_evt.sv
module tmr_evt
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] gr [NGR],
    input  logic [NGR-1:0]   cap_mode,
    input  logic [NGR-1:0]   cap_in,
    input  logic             buf_c,
    input  logic             buf_d,
    output logic [NGR-1:0]   cmp_evt,
    output logic [NGR-1:0]   cap_evt
);
    logic [NGR-1:0] blocked;
    assign blocked = {buf_d, buf_c, 2'b00};

    for (genvar i = 0; i < NGR; i++) begin : g_evt
        assign cmp_evt[i] = !blocked[i] && !cap_mode[i] && tick && (cnt == gr[i]);
        assign cap_evt[i] = !blocked[i] &&  cap_mode[i] && cap_in[i];
    end
endmodule

// File: rtl/tmr_gr_file.sv
module tmr_gr_file
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NGR-1:0]   wr_hit,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [CNT_W-1:0] cnt,
    input  logic [NGR-1:0]   cmp_evt,
    input  logic [NGR-1:0]   cap_evt,
    input  logic [1:0]       buf_on,
    output logic [CNT_W-1:0] gr [NGR]
);
    localparam int NPAIR = NGR / 2;

    for (genvar j = 0; j < NPAIR; j++) begin : g_pair
        localparam int P = j;
        localparam int S = j + NPAIR;

        always_ff @(posedge clk) begin
            if (rst) begin
                gr[P] <= '0;
                gr[S] <= '0;
            end else begin
                if (wr_hit[P])                     gr[P] <= wr_data;
                else if (cap_evt[P])               gr[P] <= cnt;
                else if (cmp_evt[P] && buf_on[j])  gr[P] <= gr[S];

                if (wr_hit[S])                     gr[S] <= wr_data;
                else if (cap_evt[S])               gr[S] <= cnt;
                else if (cap_evt[P] && buf_on[j])  gr[S] <= gr[P];
            end
        end
    end

    // R4
    cap_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_evt[0] && !wr_hit[0]) |=> (gr[0] == $past(cnt)));

    // R9
    buf_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_evt[0] && buf_on[0] && !wr_hit[2]) |=> (gr[2] == $past(gr[0])));
endmodule

// File: rtl/timer_chan_clr.sv
module timer_chan_clr
    import tmr_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter bit FULL_CLR = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [3:0]       cap_in,
    input  logic             sync_clr_in,
    output logic             sync_clr_out,
    input  logic             bus_wr,
    input  logic [2:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata
);
    localparam int PAD_W = CNT_W - CTRL_W;

    tmr_ctrl_t        ctrl;
    tmr_ctrl_t        ctrl_wr;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] gr [NGR];
    logic [NGR-1:0]   cmp_evt;
    logic [NGR-1:0]   cap_evt;
    logic [NGR-1:0]   gr_wr;
    logic             ctrl_we;
    logic             cnt_we;
    logic             clr_self;
    logic             clr_grp;
    logic             clr;

    assign ctrl_we = bus_wr && (bus_addr == ADR_CTRL);
    assign cnt_we  = bus_wr && (bus_addr == ADR_CNT);

    for (genvar i = 0; i < NGR; i++) begin : g_wdec
        assign gr_wr[i] = bus_wr && (bus_addr == 3'(int'(ADR_GRA) + i));
    end

    // Reduced variant keeps the top clear-select bit at zero
    if (FULL_CLR) begin : g_full
        assign ctrl_wr = tmr_ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end else begin : g_reduced
        tmr_ctrl_t raw;
        assign raw     = tmr_ctrl_t'(bus_wdata[CTRL_W-1:0]);
        assign ctrl_wr = '{buf_d: raw.buf_d, buf_c: raw.buf_c, cap_mode: raw.cap_mode,
                           grp_en: raw.grp_en, sel: clr_sel_e'({1'b0, raw.sel[1:0]})};
    end

    always_ff @(posedge clk) begin
        if (rst)          ctrl <= '0;
        else if (ctrl_we) ctrl <= ctrl_wr;
    end

    tmr_evt #(.CNT_W(CNT_W)) u_evt (
        .tick     (tick),
        .cnt      (cnt),
        .gr       (gr),
        .cap_mode (ctrl.cap_mode),
        .cap_in   (cap_in),
        .buf_c    (ctrl.buf_c),
        .buf_d    (ctrl.buf_d),
        .cmp_evt  (cmp_evt),
        .cap_evt  (cap_evt)
    );

    tmr_gr_file #(.CNT_W(CNT_W)) u_gr (
        .clk     (clk),
        .rst     (rst),
        .wr_hit  (gr_wr),
        .wr_data (bus_wdata),
        .cnt     (cnt),
        .cmp_evt (cmp_evt),
        .cap_evt (cap_evt),
        .buf_on  ({ctrl.buf_d, ctrl.buf_c}),
        .gr      (gr)
    );

    assign clr_self     = self_clear(ctrl.sel, cmp_evt | cap_evt);
    assign clr_grp      = is_group(ctrl.sel) && ctrl.grp_en && sync_clr_in;
    assign clr          = clr_self || clr_grp;
    assign sync_clr_out = clr_self && ctrl.grp_en;

    always_ff @(posedge clk) begin
        if (rst)         cnt <= '0;
        else if (cnt_we) cnt <= bus_wdata;
        else if (clr)    cnt <= '0;
        else if (tick)   cnt <= cnt + 1'b1;
    end

    always_comb begin
        case (bus_addr)
            ADR_CTRL: bus_rdata = {{PAD_W{1'b0}}, ctrl};
            ADR_CNT:  bus_rdata = cnt;
            ADR_GRA:  bus_rdata = gr[0];
            ADR_GRB:  bus_rdata = gr[1];
            ADR_GRC:  bus_rdata = gr[2];
            ADR_GRD:  bus_rdata = gr[3];
            default:  bus_rdata = '0;
        endcase
    end

    // R3
    self_clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_self && !cnt_we) |=> (cnt == '0));

    // R11
    cnt_wr_prio_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_we |=> (cnt == $past(bus_wdata)));

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr && !cnt_we) |=> (cnt == $past(cnt) + 1'b1));

    // R7
    sync_out_en_chk: assert property (@(posedge clk) disable iff (rst)
        sync_clr_out |-> ctrl.grp_en);

    // R8
    buf_no_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.buf_c && ctrl.sel == CLR_C) |-> !clr_self);

    // R5
    off_code_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.sel[1:0] == 2'b00) |-> !clr);
endmodule

// File: tb/tb_timer_chan_clr.sv
module tb_timer_chan_clr;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [3:0]  cap_in = '0;
    logic        sync_clr_in = 1'b0;
    logic        sync_clr_out, sync_clr_out_r;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata, bus_rdata_r;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    timer_chan_clr #(.CNT_W(16), .FULL_CLR(1'b1)) dut (
        .clk(clk), .rst(rst), .tick(tick), .cap_in(cap_in),
        .sync_clr_in(sync_clr_in), .sync_clr_out(sync_clr_out),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata));

    timer_chan_clr #(.CNT_W(16), .FULL_CLR(1'b0)) dut_r (
        .clk(clk), .rst(rst), .tick(tick), .cap_in(cap_in),
        .sync_clr_in(sync_clr_in), .sync_clr_out(sync_clr_out_r),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata_r));

    // {clear-select code, counter after 10 ticks, sync pulses}
    // A=5 B=6 C=7 D=8, all compare mode, group-sync enabled
    localparam logic [2:0]  VSEL [8] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
    localparam logic [15:0] VCNT [8] = '{16'd10, 16'd4, 16'd3, 16'd10, 16'd10, 16'd2, 16'd1, 16'd10};
    localparam int          VPUL [8] = '{0, 1, 1, 0, 0, 1, 1, 0};

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic run(input int n, output int pulses);
        pulses = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick = 1'b1;
            #1;
            if (sync_clr_out) pulses++;
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic strobe(input logic [3:0] c, input logic s);
        @(negedge clk);
        cap_in = c; sync_clr_in = s;
        @(negedge clk);
        cap_in = '0; sync_clr_in = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int p;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(3'd0, 16'h0, "R1 ctrl");
        rd(3'd1, 16'h0, "R1 cnt");
        for (int i = 0; i < 4; i++) rd(3'(2 + i), 16'h0, "R1 gr");

        // Vector table: every clear-select code (R3 R5 R6 R7)
        wr(3'd2, 16'd5); wr(3'd3, 16'd6); wr(3'd4, 16'd7); wr(3'd5, 16'd8);
        for (int v = 0; v < 8; v++) begin
            wr(3'd0, {12'h0, 1'b1, VSEL[v]});
            wr(3'd1, 16'd0);
            run(10, p);
            rd(3'd1, VCNT[v], $sformatf("R3 R5 code %0d count", VSEL[v]));
            chk($sformatf("R7 code %0d pulses", VSEL[v]), 16'(p), 16'(VPUL[v]));
        end

        // R2: wrap
        wr(3'd0, 16'h0);
        wr(3'd1, 16'hFFFF);
        run(1, p);
        rd(3'd1, 16'h0, "R2 wrap");

        // R4: capture on A clears and latches
        wr(3'd0, 16'h0011);
        wr(3'd1, 16'd100);
        strobe(4'b0001, 1'b0);
        rd(3'd2, 16'd100, "R4 capture value");
        rd(3'd1, 16'd0, "R4 capture clear");

        // R6: group clear gated by enable
        wr(3'd0, 16'h0003);
        wr(3'd1, 16'h0020);
        strobe(4'b0000, 1'b1);
        rd(3'd1, 16'h0020, "R6 enable low no clear");
        wr(3'd0, 16'h000F);
        strobe(4'b0000, 1'b1);
        rd(3'd1, 16'h0000, "R6 enable high clears");

        // R8: buffering C never clears
        wr(3'd0, 16'h0105);
        wr(3'd4, 16'd3);
        wr(3'd2, 16'd40);
        wr(3'd1, 16'd0);
        run(6, p);
        rd(3'd1, 16'd6, "R8 buffered C no clear");

        // R9: buffer transfers
        wr(3'd0, 16'h0110);
        wr(3'd2, 16'h0011);
        wr(3'd1, 16'h0040);
        strobe(4'b0001, 1'b0);
        rd(3'd2, 16'h0040, "R9 capture into A");
        rd(3'd4, 16'h0011, "R9 old A into C");
        wr(3'd0, 16'h0100);
        wr(3'd4, 16'h0033);
        wr(3'd2, 16'd2);
        wr(3'd1, 16'd0);
        run(3, p);
        rd(3'd2, 16'h0033, "R9 compare reload A");

        // R11: counter write beats clear
        wr(3'd0, 16'h0001);
        wr(3'd2, 16'd5);
        wr(3'd1, 16'd5);
        @(negedge clk);
        tick = 1'b1; bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 16'h0077;
        @(negedge clk);
        tick = 1'b0; bus_wr = 1'b0;
        rd(3'd1, 16'h0077, "R11 write priority");

        // R10: reduced variant masks top select bit
        wr(3'd0, 16'h0005);
        rd(3'd0, 16'h0005, "R10 full keeps 101");
        bus_addr = 3'd0; #1;
        chk("R10 reduced reads 001", bus_rdata_r, 16'h0001);
        wr(3'd0, 16'h0006);
        bus_addr = 3'd0; #1;
        chk("R10 reduced reads 010", bus_rdata_r, 16'h0002);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule